// File: doc/BRIEF.md
# One-Shot Edge-Aligned PWM Generator

This block is a PWM time base with per-channel duty comparators. A counter starts at zero when software sets the run-enable bit. It counts up by one per clock until it equals the programmed period. Each channel output goes active when the run starts and goes inactive once the counter reaches that channel's duty value.

In single-pulse mode the period match ends the run. The counter returns to zero, every channel is forced inactive, the run-enable bit clears itself and an interrupt is raised, so the generator makes exactly one pulse per start. In free-running mode the same period match wraps the counter to zero and re-arms the channels, and the run continues until software stops it. Both modes are built in so that their behaviour can be compared side by side.

The channel outputs are raw and active-high. Polarity, dead time, overrides and fault handling are applied by a separate output stage downstream.

Top module: `pwm_oneshot_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `chan_out`, `count`, `run_en`, `period_irq` and `irq_flag` are all zero.
- R2: A `run_set` pulse while `run_en` is 0 (and `run_clr` is 0) makes `run_en` 1 and `count` 0 on the next cycle. On that same cycle each channel whose duty value is nonzero becomes active.
- R3: While running, `count` rises by one per cycle until it equals `period`. A channel goes inactive on the cycle where `count` equals its duty value and stays inactive for the rest of that pass.
- R4: A channel with duty value 0 is never active. A channel whose duty value is above `period` stays active until the period match ends the pass.
- R5: With `mode` = 2'b10 (single pulse), the cycle after `count` equals `period` shows `count` = 0, all channels inactive and `run_en` = 0.
- R6: `period_irq` is high for exactly one cycle, on the cycle after each period match, in every mode.
- R7: `irq_flag` is set by every period match and stays set until a `flag_clr` pulse clears it. If a period match and `flag_clr` fall in the same cycle, the flag is set.
- R8: With `mode` = 2'b00, or with the unused codes 2'b01 and 2'b11, a period match wraps `count` to 0 and re-activates the channels with nonzero duty, and `run_en` stays 1.
- R9: While `run_en` is 0, `count` holds at 0 and all channels stay inactive. A `run_set` pulse while `run_en` is 1 has no effect on `count`, `run_en` or the outputs.
- R10: A `run_clr` pulse makes `run_en`, `count` and `chan_out` all zero on the next cycle. It takes priority over a simultaneous `run_set`, and it suppresses the period interrupt if it coincides with a period match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 2'b10 single pulse; any other value free-running edge-aligned |
| run_set | input | 1 | Pulse: write 1 to the run-enable bit |
| run_clr | input | 1 | Pulse: write 0 to the run-enable bit |
| flag_clr | input | 1 | Pulse: clear the sticky interrupt flag |
| period | input | CNT_W | Period value, the last count of a pass |
| duty | input | NUM_CH*CNT_W | Duty values; channel c uses bits [c*CNT_W +: CNT_W] |
| chan_out | output | NUM_CH | Raw active-high channel outputs |
| count | output | CNT_W | Current counter value |
| run_en | output | 1 | Run-enable bit; falls by itself when a single shot ends |
| period_irq | output | 1 | One-cycle interrupt pulse after a period match |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
Two pairs of events can land in the same cycle. The first pair is the period match that ends a shot and a software write. A `flag_clr` is driven in exactly the cycle where `count` equals `period`, and the flag is expected to read 1 afterwards, then 0 after one more cycle of `flag_clr`. A `run_set` during a running shot is expected to leave the count sequence and the end of the shot unchanged. The second pair is a `run_clr` that collides with `run_set` on an idle generator, or with a period match. In both cases the generator must stay stopped with no interrupt.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    MODE_FREE   = 2'b00,
    MODE_RSVD1  = 2'b01,
    MODE_SINGLE = 2'b10,
    MODE_RSVD3  = 2'b11
  } pwm_mode_e;

  function automatic logic is_single(input logic [1:0] m);
    return m == MODE_SINGLE;
  endfunction
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             run_set,
  input  logic             run_clr,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next,
  output logic             run_q,
  output logic             start,
  output logic             wrap,
  output logic             shot_end
);
  import pwm_pkg::*;

  logic at_period;
  logic run_next;

  always_comb begin
    at_period = run_q && (cnt_q == period);
    start     = run_set && !run_q && !run_clr;
    wrap      = at_period && !run_clr;
    shot_end  = wrap && is_single(mode);

    if (run_clr || start)   cnt_next = '0;
    else if (at_period)     cnt_next = '0;
    else if (run_q)         cnt_next = cnt_q + CNT_W'(1);
    else                    cnt_next = cnt_q;

    if (run_clr)            run_next = 1'b0;
    else if (start)         run_next = 1'b1;
    else if (shot_end)      run_next = 1'b0;
    else                    run_next = run_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_next;
      run_q <= run_next;
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kill,
  input  logic             arm,
  input  logic             running,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic [CNT_W-1:0] duty,
  output logic             out_q
);
  logic duty_nz;
  assign duty_nz = |duty;

  always_ff @(posedge clk) begin
    if (rst)                                  out_q <= 1'b0;
    else if (kill)                            out_q <= 1'b0;
    else if (arm)                             out_q <= duty_nz;
    else if (running && cnt_next == duty)     out_q <= 1'b0;
  end
endmodule

// File: rtl/pwm_irq.sv
module pwm_irq (
  input  logic clk,
  input  logic rst,
  input  logic match,
  input  logic flag_clr,
  output logic pulse_q,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= match;
      if (match)         flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_oneshot_gen.sv
module pwm_oneshot_gen #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              mode,
  input  logic                    run_set,
  input  logic                    run_clr,
  input  logic                    flag_clr,
  input  logic [CNT_W-1:0]        period,
  input  logic [NUM_CH*CNT_W-1:0] duty,
  output logic [NUM_CH-1:0]       chan_out,
  output logic [CNT_W-1:0]        count,
  output logic                    run_en,
  output logic                    period_irq,
  output logic                    irq_flag
);
  localparam int DUTY_W = NUM_CH * CNT_W;

  logic [CNT_W-1:0] cnt_next;
  logic             start, wrap, shot_end;
  logic             kill, arm;
  logic [DUTY_W-1:0] duty_w;

  assign duty_w = duty;

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .run_set  (run_set),
    .run_clr  (run_clr),
    .period   (period),
    .cnt_q    (count),
    .cnt_next (cnt_next),
    .run_q    (run_en),
    .start    (start),
    .wrap     (wrap),
    .shot_end (shot_end)
  );

  assign kill = run_clr || shot_end;
  assign arm  = start || wrap;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_chan #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .kill     (kill),
      .arm      (arm),
      .running  (run_en),
      .cnt_next (cnt_next),
      .duty     (duty_w[c*CNT_W +: CNT_W]),
      .out_q    (chan_out[c])
    );
  end

  pwm_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .match    (wrap),
    .flag_clr (flag_clr),
    .pulse_q  (period_irq),
    .flag_q   (irq_flag)
  );
endmodule

// File: rtl/pwm_oneshot_chk.sv
module pwm_oneshot_chk #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic [1:0]              mode,
  input logic                    run_set,
  input logic                    run_clr,
  input logic [CNT_W-1:0]        period,
  input logic [NUM_CH-1:0]       chan_out,
  input logic [CNT_W-1:0]        count,
  input logic                    run_en,
  input logic                    period_irq,
  input logic                    irq_flag
);
  // R2
  start_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (run_set && !run_en && !run_clr) |=> (run_en && count == '0));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run_en && !run_clr && count != period) |=> (count == $past(count) + CNT_W'(1)));

  // R5
  shot_end_chk: assert property (@(posedge clk) disable iff (rst)
    (run_en && !run_clr && count == period && mode == 2'b10)
      |=> (!run_en && count == '0 && chan_out == '0));

  // R6
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (run_en && !run_clr && count == period) |=> period_irq);

  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    period_irq |=> !period_irq);

  // R7
  flag_follow_chk: assert property (@(posedge clk) disable iff (rst)
    period_irq |-> irq_flag);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run_en |-> (count == '0 && chan_out == '0));

  // R10
  stop_chk: assert property (@(posedge clk) disable iff (rst)
    run_clr |=> (!run_en && count == '0 && chan_out == '0 && !period_irq));
endmodule

bind pwm_oneshot_gen pwm_oneshot_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode       (mode),
  .run_set    (run_set),
  .run_clr    (run_clr),
  .period     (period),
  .chan_out   (chan_out),
  .count      (count),
  .run_en     (run_en),
  .period_irq (period_irq),
  .irq_flag   (irq_flag)
);

// File: tb/pwm_oneshot_gen_tb.sv
module pwm_oneshot_gen_tb;
  localparam int CNT_W  = 16;
  localparam int NUM_CH = 4;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [1:0]              mode = 2'b10;
  logic                    run_set = 1'b0;
  logic                    run_clr = 1'b0;
  logic                    flag_clr = 1'b0;
  logic [CNT_W-1:0]        period = '0;
  logic [NUM_CH*CNT_W-1:0] duty = '0;
  logic [NUM_CH-1:0]       chan_out;
  logic [CNT_W-1:0]        count;
  logic                    run_en;
  logic                    period_irq;
  logic                    irq_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_oneshot_gen #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_dut (
    .clk(clk), .rst(rst), .mode(mode), .run_set(run_set), .run_clr(run_clr),
    .flag_clr(flag_clr), .period(period), .duty(duty), .chan_out(chan_out),
    .count(count), .run_en(run_en), .period_irq(period_irq), .irq_flag(irq_flag)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [NUM_CH-1:0] exp_out(input int k, input int d0, input int d1,
                                                input int d2, input int d3);
    int d [4];
    logic [NUM_CH-1:0] v;
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    for (int c = 0; c < NUM_CH; c++) v[c] = (d[c] != 0) && (k < d[c]);
    return v;
  endfunction

  // Runs a pass sequence and checks every cycle; free modes are stopped with run_clr.
  task automatic run_seq(input string req, input logic [1:0] m, input int p,
                         input int d0, input int d1, input int d2, input int d3,
                         input int ncyc);
    int k;
    bit single;
    single = (m == 2'b10);
    mode = m;
    period = CNT_W'(p);
    duty = {CNT_W'(d3), CNT_W'(d2), CNT_W'(d1), CNT_W'(d0)};
    run_set = 1'b1;
    step();
    run_set = 1'b0;
    k = 0;
    for (int i = 0; i < ncyc; i++) begin
      check(req, "count", int'(count), k);
      check(req, "run_en", int'(run_en), 1);
      check(req, "chan_out", int'(chan_out), int'(exp_out(k, d0, d1, d2, d3)));
      check("R6", "period_irq", int'(period_irq), (i > 0 && k == 0) ? 1 : 0);
      if (k == p) begin
        if (single) begin
          step();
          check("R5", "end count", int'(count), 0);
          check("R5", "end run_en", int'(run_en), 0);
          check("R5", "end chan_out", int'(chan_out), 0);
          check("R6", "end period_irq", int'(period_irq), 1);
          check("R7", "end irq_flag", int'(irq_flag), 1);
          step();
          check("R6", "irq drops", int'(period_irq), 0);
          check("R9", "count holds", int'(count), 0);
          check("R9", "outputs idle", int'(chan_out), 0);
          return;
        end
        k = 0;
      end else begin
        k++;
      end
      step();
    end
    run_clr = 1'b1;
    step();
    run_clr = 1'b0;
    check("R10", "stop run_en", int'(run_en), 0);
    check("R10", "stop count", int'(count), 0);
    check("R10", "stop chan_out", int'(chan_out), 0);
  endtask

  task automatic t_reset();
    repeat (3) step();
    check("R1", "chan_out in reset", int'(chan_out), 0);
    rst = 1'b0;
    step();
    check("R1", "chan_out", int'(chan_out), 0);
    check("R1", "count", int'(count), 0);
    check("R1", "run_en", int'(run_en), 0);
    check("R1", "period_irq", int'(period_irq), 0);
    check("R1", "irq_flag", int'(irq_flag), 0);
  endtask

  task automatic t_flag_clear();
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
    check("R7", "flag cleared", int'(irq_flag), 0);
  endtask

  task automatic t_single_basic();
    // R2 R3 R4 R5: distinct duties, one zero, one above period
    run_seq("R3", 2'b10, 7, 3, 0, 9, 7, 20);
    step();
    check("R7", "flag sticky", int'(irq_flag), 1);
    t_flag_clear();
  endtask

  task automatic t_single_again();
    // R2: retrigger after a finished shot
    run_seq("R2", 2'b10, 4, 1, 2, 4, 5, 10);
    t_flag_clear();
  endtask

  task automatic t_free_modes();
    run_seq("R8", 2'b00, 5, 2, 4, 0, 6, 15);
    run_seq("R8", 2'b01, 3, 1, 3, 2, 0, 9);
    run_seq("R8", 2'b11, 2, 1, 1, 5, 2, 8);
    t_flag_clear();
  endtask

  task automatic t_flag_collide();
    mode = 2'b10;
    period = CNT_W'(3);
    duty = {CNT_W'(1), CNT_W'(1), CNT_W'(1), CNT_W'(2)};
    run_set = 1'b1;
    step();
    run_set = 1'b0;
    step(); step(); step();
    check("R7", "count at match", int'(count), 3);
    flag_clr = 1'b1;
    step();
    check("R7", "set wins over clear", int'(irq_flag), 1);
    step();
    flag_clr = 1'b0;
    check("R7", "clear next cycle", int'(irq_flag), 0);
  endtask

  task automatic t_set_while_running();
    mode = 2'b10;
    period = CNT_W'(5);
    duty = {CNT_W'(4), CNT_W'(3), CNT_W'(2), CNT_W'(1)};
    run_set = 1'b1;
    step();
    run_set = 1'b0;
    step(); step();
    check("R9", "count before set", int'(count), 2);
    run_set = 1'b1;
    step();
    run_set = 1'b0;
    check("R9", "count after ignored set", int'(count), 3);
    check("R9", "chan_out after ignored set", int'(chan_out), 4'b1000);
    step(); step();
    check("R9", "count at period", int'(count), 5);
    step();
    check("R9", "shot ended on time", int'(run_en), 0);
    t_flag_clear();
  endtask

  task automatic t_clr_priority();
    mode = 2'b10;
    period = CNT_W'(4);
    duty = {4{CNT_W'(2)}};
    run_set = 1'b1;
    run_clr = 1'b1;
    step();
    run_set = 1'b0;
    run_clr = 1'b0;
    check("R10", "clr beats set", int'(run_en), 0);
    check("R10", "outputs stay off", int'(chan_out), 0);
    // run_clr on the period-match cycle suppresses the interrupt
    run_set = 1'b1;
    step();
    run_set = 1'b0;
    repeat (4) step();
    check("R10", "count at match", int'(count), 4);
    run_clr = 1'b1;
    step();
    run_clr = 1'b0;
    check("R10", "no irq on stop", int'(period_irq), 0);
    check("R10", "no flag on stop", int'(irq_flag), 0);
    check("R10", "stopped", int'(run_en), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_single_basic();
    t_single_again();
    t_free_modes();
    t_flag_collide();
    t_set_while_running();
    t_clr_priority();
    repeat (3) step();
    check("R9", "idle count", int'(count), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule